// File: doc/BRIEF.md
# Speculation Control Register Unit

This block is a register slave on the core's model-specific register path. It answers reads and writes for four 64-bit registers. The first is a stored speculation-control register that holds three mode bits. The second and third are write-only command registers that fire a one-cycle pulse toward the branch predictors or the L1 data cache. The fourth is a read-only capability word driven from straps. Feature straps decide which bits may be written. An illegal access returns an error and changes nothing.

Each write is ordered against the rest of the core. After it is accepted, the block waits until `drained_i` shows that all older operations have finished locally. Only then does it update the register or issue the pulse. The acknowledge comes one cycle after that update or pulse. Reads need no drain and acknowledge one cycle after acceptance. In enclave or system-management mode, the store-bypass block output is forced on. The stored bit keeps its value.

Top module: `spec_ctl_unit`

## Requirements
- R1: After reset the control register reads 0, all mode and pulse outputs are 0 and `ack_o` is 0.
- R2: Index 0x48 is the control register. Bit 0 is restricted speculation (`restrict_o`), bit 1 is sibling-thread isolation (`isolate_o`) and bit 2 is store-bypass blocking. Bits 63:3 are reserved, and a write that sets any of them faults.
- R3: A write that sets bit 0 of 0x48 faults when `feat_restrict_i` is 0. A write that sets bit 2 faults when `feat_ssbd_i` is 0. When all three of `feat_restrict_i`, `feat_isolate_i` and `feat_ssbd_i` are 0, any access to 0x48 faults.
- R4: When the register is present but `feat_isolate_i` is 0, bit 1 of a write is dropped without a fault and reads back as 0.
- R5: Index 0x49 is write-only and needs `feat_restrict_i`. Writing 1 to bit 0 gives one single-cycle `barrier_pulse_o` on every such write. Writing 0 is accepted and gives no pulse. Setting bits 63:1 or reading the register faults.
- R6: Index 0x10B is write-only and needs `feat_flush_i`. Writing 1 to bit 0 gives one single-cycle `flush_pulse_o`. Upper bits, reads and a missing feature fault.
- R7: Index 0x10A reads `cap_strap_i` in bits 8:0 and zero in bits 63:9. A write to it faults.
- R8: Any other index faults.
- R9: A write takes effect (register update or pulse) only in the cycle after an edge at which `drained_i` is 1. `ack_o` rises for one cycle in the cycle after the effect. With `drained_i` held at 1, a write acknowledges in the third cycle after acceptance and a read in the first.
- R10: The request fields are captured at acceptance. No new request is taken until the current one has been acknowledged, and changes on the request inputs in the meantime have no effect.
- R11: `init_i` leaves the control register unchanged. It abandons a write still waiting for drain, without effect and without acknowledge.
- R12: While `enclave_i` or `smm_i` is 1, `bypass_block_o` is 1 whatever the stored bit 2 is. The stored bit still reads back unchanged.
- R13: A faulting access acknowledges with `err_o`=1 and `rdata_o`=0 and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Soft init: abandons a pending write, keeps the register |
| feat_restrict_i | input | 1 | Strap: restricted speculation and predictor barrier supported |
| feat_isolate_i | input | 1 | Strap: sibling-thread isolation supported |
| feat_ssbd_i | input | 1 | Strap: store-bypass blocking supported |
| feat_flush_i | input | 1 | Strap: L1 data flush command supported |
| cap_strap_i | input | 9 | Capability bits returned by index 0x10A |
| enclave_i | input | 1 | Core is executing in an enclave |
| smm_i | input | 1 | Core is in system-management mode |
| req_i | input | 1 | Access request, held until `ack_o` |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 32 | Register index |
| req_wdata_i | input | 64 | Write data |
| drained_i | input | 1 | All older operations have completed |
| ack_o | output | 1 | One-cycle completion |
| err_o | output | 1 | Fault response, valid with `ack_o` |
| rdata_o | output | 64 | Read data, valid with `ack_o` |
| restrict_o | output | 1 | Restricted speculation mode |
| isolate_o | output | 1 | Sibling-thread isolation mode |
| bypass_block_o | output | 1 | Effective store-bypass blocking |
| barrier_pulse_o | output | 1 | One-cycle predictor barrier command |
| flush_pulse_o | output | 1 | One-cycle L1 data write-back-and-invalidate command |

## Verification
On every cycle, the assertions check the following:
- both command pulses last a single cycle;
- a pulse only follows an edge where `drained_i` was high, and is followed by the acknowledge;
- acknowledges never last two cycles;
- a faulting apply leaves the register still;
- the isolation and restriction bits never rise without their straps;
- the bypass-block output is always on in enclave or system-management mode.

Only the bench scenarios can show the rest: which access patterns fault under each strap combination, the exact read data including the dropped isolation bit, the capability word, latency counts, that a request changed mid-flight keeps its captured values, and that init abandons a waiting write while the register survives.

// File: rtl/spec_ctl_pkg.sv
package spec_ctl_pkg;

    localparam int SC_DW     = 64;
    localparam int SC_CAP_W  = 9;
    localparam int SC_CTRL_W = 3;

    localparam logic [31:0] IDX_CTRL  = 32'h0000_0048;
    localparam logic [31:0] IDX_PRED  = 32'h0000_0049;
    localparam logic [31:0] IDX_CAP   = 32'h0000_010A;
    localparam logic [31:0] IDX_FLUSH = 32'h0000_010B;

    localparam int B_RESTRICT = 0;
    localparam int B_ISOLATE  = 1;
    localparam int B_BYPASS   = 2;
    localparam int B_CMD      = 0;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_PRED,
        TGT_FLUSH,
        TGT_CAP
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_ISSUE,
        ST_RESP
    } seq_e;

    typedef struct packed {
        logic restrict_ok;
        logic isolate_ok;
        logic ssbd_ok;
        logic flush_ok;
    } feat_t;

    typedef struct packed {
        tgt_e                 tgt;
        logic                 err;
        logic [SC_CTRL_W-1:0] wval;
        logic [SC_DW-1:0]     rval;
    } dec_t;

    // control bits that can be stored
    function automatic logic [SC_CTRL_W-1:0] ctrl_keep(feat_t f);
        logic [SC_CTRL_W-1:0] r;
        r = '0;
        r[B_RESTRICT] = f.restrict_ok;
        r[B_ISOLATE]  = f.isolate_ok;
        r[B_BYPASS]   = f.ssbd_ok;
        return r;
    endfunction

    // control bits silently dropped instead of faulting
    function automatic logic [SC_CTRL_W-1:0] ctrl_drop(feat_t f);
        logic [SC_CTRL_W-1:0] r;
        r = '0;
        r[B_ISOLATE] = !f.isolate_ok;
        return r;
    endfunction

    function automatic logic ctrl_present(feat_t f);
        return f.restrict_ok | f.isolate_ok | f.ssbd_ok;
    endfunction

endpackage

// File: rtl/spec_ctl_decode.sv
module spec_ctl_decode
    import spec_ctl_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 wr_i,
    input  logic [SC_DW-1:0]     wdata_i,
    input  feat_t                feat_i,
    input  logic [SC_CAP_W-1:0]  cap_i,
    input  logic [SC_CTRL_W-1:0] ctrl_i,
    output dec_t                 dec_o
);

    localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] I_PRED  = IDX_W'(IDX_PRED);
    localparam logic [IDX_W-1:0] I_CAP   = IDX_W'(IDX_CAP);
    localparam logic [IDX_W-1:0] I_FLUSH = IDX_W'(IDX_FLUSH);
    localparam int               HI_W    = SC_DW - SC_CTRL_W;

    logic [SC_CTRL_W-1:0] keep;
    logic [SC_DW-1:0]     rsv;
    logic                 cmd_upper;

    always_comb begin
        keep      = ctrl_keep(feat_i);
        rsv       = ~{{HI_W{1'b0}}, keep | ctrl_drop(feat_i)};
        cmd_upper = |wdata_i[SC_DW-1:1];

        dec_o      = '0;
        dec_o.tgt  = TGT_NONE;
        dec_o.err  = 1'b1;

        case (idx_i)
            I_CTRL: begin
                if (ctrl_present(feat_i)) begin
                    dec_o.tgt  = TGT_CTRL;
                    dec_o.err  = wr_i && (|(wdata_i & rsv));
                    dec_o.wval = wdata_i[SC_CTRL_W-1:0] & keep;
                    dec_o.rval = SC_DW'(ctrl_i);
                end
            end
            I_PRED: begin
                if (feat_i.restrict_ok) begin
                    dec_o.tgt  = TGT_PRED;
                    dec_o.err  = !wr_i || cmd_upper;
                    dec_o.wval = SC_CTRL_W'(wdata_i[B_CMD]);
                end
            end
            I_FLUSH: begin
                if (feat_i.flush_ok) begin
                    dec_o.tgt  = TGT_FLUSH;
                    dec_o.err  = !wr_i || cmd_upper;
                    dec_o.wval = SC_CTRL_W'(wdata_i[B_CMD]);
                end
            end
            I_CAP: begin
                dec_o.tgt  = TGT_CAP;
                dec_o.err  = wr_i;
                dec_o.rval = SC_DW'(cap_i);
            end
            default: ;
        endcase

        if (dec_o.err || wr_i) begin
            dec_o.rval = '0;
        end
    end

endmodule

// File: rtl/spec_ctl_seq.sv
module spec_ctl_seq
    import spec_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             req_i,
    input  logic             wr_i,
    input  dec_t             dec_i,
    input  logic             drained_i,
    output dec_t             held_o,
    output logic             apply_o,
    output logic             ack_o,
    output logic             err_o,
    output logic [SC_DW-1:0] rdata_o
);

    seq_e state;
    dec_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '0;
        end else if (init_i) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_i) begin
                        held  <= dec_i;
                        state <= wr_i ? ST_DRAIN : ST_RESP;
                    end
                end
                ST_DRAIN: begin
                    if (drained_i) begin
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign apply_o = (state == ST_DRAIN) && drained_i && !init_i;
    assign ack_o   = (state == ST_RESP);
    assign err_o   = ack_o && held.err;
    assign rdata_o = ack_o ? held.rval : '0;
    assign held_o  = held;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o) else $error("ack held twice"); // R10

endmodule

// File: rtl/spec_ctl_regs.sv
module spec_ctl_regs
    import spec_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 apply_i,
    input  tgt_e                 tgt_i,
    input  logic                 err_i,
    input  logic [SC_CTRL_W-1:0] wval_i,
    input  feat_t                feat_i,
    input  logic                 enclave_i,
    input  logic                 smm_i,
    output logic [SC_CTRL_W-1:0] ctrl_o,
    output logic                 bypass_o,
    output logic                 barrier_o,
    output logic                 flush_o
);

    logic [SC_CTRL_W-1:0] ctrl_q;
    logic                 barrier_q;
    logic                 flush_q;
    logic                 ok;

    assign ok = apply_i && !err_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            barrier_q <= 1'b0;
            flush_q   <= 1'b0;
        end else begin
            barrier_q <= ok && (tgt_i == TGT_PRED)  && wval_i[B_CMD];
            flush_q   <= ok && (tgt_i == TGT_FLUSH) && wval_i[B_CMD];
            if (ok && (tgt_i == TGT_CTRL)) begin
                ctrl_q <= wval_i;
            end
        end
    end

    assign ctrl_o    = ctrl_q;
    assign bypass_o  = ctrl_q[B_BYPASS] | enclave_i | smm_i;
    assign barrier_o = barrier_q;
    assign flush_o   = flush_q;

    AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (apply_i && err_i) |=> $stable(ctrl_q)) else $error("fault changed state"); // R13
    AST_ISO_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[B_ISOLATE]) |-> feat_i.isolate_ok) else $error("isolation bit stored"); // R4
    AST_RESTRICT_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[B_RESTRICT]) |-> feat_i.restrict_ok) else $error("restrict bit stored"); // R3
    AST_BARRIER_ONE: assert property (@(posedge clk) disable iff (rst)
        barrier_q |=> !barrier_q) else $error("barrier pulse too long"); // R5
    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (rst)
        flush_q |=> !flush_q) else $error("flush pulse too long"); // R6

endmodule

// File: rtl/spec_ctl_unit.sv
module spec_ctl_unit
    import spec_ctl_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_i,
    input  logic                feat_restrict_i,
    input  logic                feat_isolate_i,
    input  logic                feat_ssbd_i,
    input  logic                feat_flush_i,
    input  logic [SC_CAP_W-1:0] cap_strap_i,
    input  logic                enclave_i,
    input  logic                smm_i,
    input  logic                req_i,
    input  logic                req_wr_i,
    input  logic [IDX_W-1:0]    req_idx_i,
    input  logic [SC_DW-1:0]    req_wdata_i,
    input  logic                drained_i,
    output logic                ack_o,
    output logic                err_o,
    output logic [SC_DW-1:0]    rdata_o,
    output logic                restrict_o,
    output logic                isolate_o,
    output logic                bypass_block_o,
    output logic                barrier_pulse_o,
    output logic                flush_pulse_o
);

    feat_t                feat;
    dec_t                 dec;
    dec_t                 held;
    logic                 apply;
    logic [SC_CTRL_W-1:0] ctrl;

    assign feat.restrict_ok = feat_restrict_i;
    assign feat.isolate_ok  = feat_isolate_i;
    assign feat.ssbd_ok     = feat_ssbd_i;
    assign feat.flush_ok    = feat_flush_i;

    spec_ctl_decode #(.IDX_W(IDX_W)) u_dec (
        .idx_i   (req_idx_i),
        .wr_i    (req_wr_i),
        .wdata_i (req_wdata_i),
        .feat_i  (feat),
        .cap_i   (cap_strap_i),
        .ctrl_i  (ctrl),
        .dec_o   (dec)
    );

    spec_ctl_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .init_i    (init_i),
        .req_i     (req_i),
        .wr_i      (req_wr_i),
        .dec_i     (dec),
        .drained_i (drained_i),
        .held_o    (held),
        .apply_o   (apply),
        .ack_o     (ack_o),
        .err_o     (err_o),
        .rdata_o   (rdata_o)
    );

    spec_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .apply_i   (apply),
        .tgt_i     (held.tgt),
        .err_i     (held.err),
        .wval_i    (held.wval),
        .feat_i    (feat),
        .enclave_i (enclave_i),
        .smm_i     (smm_i),
        .ctrl_o    (ctrl),
        .bypass_o  (bypass_block_o),
        .barrier_o (barrier_pulse_o),
        .flush_o   (flush_pulse_o)
    );

    assign restrict_o = ctrl[B_RESTRICT];
    assign isolate_o  = ctrl[B_ISOLATE];

    AST_FORCE_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (enclave_i || smm_i) |-> bypass_block_o) else $error("bypass not forced"); // R12
    AST_BARRIER_DRAINED: assert property (@(posedge clk) disable iff (rst)
        barrier_pulse_o |-> $past(drained_i)) else $error("barrier before drain"); // R9
    AST_FLUSH_DRAINED: assert property (@(posedge clk) disable iff (rst)
        flush_pulse_o |-> $past(drained_i)) else $error("flush before drain"); // R9
    AST_ACK_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        ((barrier_pulse_o || flush_pulse_o) && !init_i) |=> ack_o) else $error("no ack after pulse"); // R9

endmodule

// File: tb/sim_spec_ctl_unit.sv
module sim_spec_ctl_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] idx;
        logic [63:0] data;
        logic        err;
        logic [63:0] rd;
        logic [1:0]  nb;
        logic [1:0]  nf;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h48,  64'h5, 1'b0, 64'h0,  2'd0, 2'd0, 8'd2},  // R2 store 5
        '{1'b0, 32'h48,  64'h0, 1'b0, 64'h5,  2'd0, 2'd0, 8'd2},  // R2 read back
        '{1'b1, 32'h48,  64'h8, 1'b1, 64'h0,  2'd0, 2'd0, 8'd2},  // R2 reserved bit 3
        '{1'b0, 32'h48,  64'h0, 1'b0, 64'h5,  2'd0, 2'd0, 8'd13}, // R13 unchanged
        '{1'b1, 32'h49,  64'h1, 1'b0, 64'h0,  2'd1, 2'd0, 8'd5},  // R5 barrier
        '{1'b1, 32'h49,  64'h1, 1'b0, 64'h0,  2'd1, 2'd0, 8'd5},  // R5 again, no clear
        '{1'b1, 32'h49,  64'h0, 1'b0, 64'h0,  2'd0, 2'd0, 8'd5},  // R5 zero write
        '{1'b1, 32'h49,  64'h2, 1'b1, 64'h0,  2'd0, 2'd0, 8'd5},  // R5 upper bit
        '{1'b0, 32'h49,  64'h0, 1'b1, 64'h0,  2'd0, 2'd0, 8'd5},  // R5 read faults
        '{1'b1, 32'h10B, 64'h1, 1'b0, 64'h0,  2'd0, 2'd1, 8'd6},  // R6 flush
        '{1'b0, 32'h10B, 64'h0, 1'b1, 64'h0,  2'd0, 2'd0, 8'd6},  // R6 read faults
        '{1'b0, 32'h10A, 64'h0, 1'b0, 64'hA5, 2'd0, 2'd0, 8'd7},  // R7 capability
        '{1'b1, 32'h10A, 64'h1, 1'b1, 64'h0,  2'd0, 2'd0, 8'd7},  // R7 write faults
        '{1'b0, 32'h50,  64'h0, 1'b1, 64'h0,  2'd0, 2'd0, 8'd8},  // R8 unknown index
        '{1'b1, 32'h48,  64'h7, 1'b0, 64'h0,  2'd0, 2'd0, 8'd2},  // R2 all bits
        '{1'b0, 32'h48,  64'h0, 1'b0, 64'h7,  2'd0, 2'd0, 8'd2}   // R2 read all
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        init_i = 0;
    logic        f_res = 1, f_iso = 1, f_ssb = 1, f_fl = 1;
    logic [8:0]  cap = 9'h0A5;
    logic        enclave = 0, smm = 0;
    logic        req = 0, wr = 0;
    logic [31:0] idx = '0;
    logic [63:0] wdata = '0;
    logic        drained = 1;
    logic        ack, err;
    logic [63:0] rdata;
    logic        res_o, iso_o, byp_o, bar_o, fl_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_ctl_unit u0 (
        .clk(clk), .rst(rst), .init_i(init_i),
        .feat_restrict_i(f_res), .feat_isolate_i(f_iso), .feat_ssbd_i(f_ssb), .feat_flush_i(f_fl),
        .cap_strap_i(cap), .enclave_i(enclave), .smm_i(smm),
        .req_i(req), .req_wr_i(wr), .req_idx_i(idx), .req_wdata_i(wdata),
        .drained_i(drained), .ack_o(ack), .err_o(err), .rdata_o(rdata),
        .restrict_o(res_o), .isolate_o(iso_o), .bypass_block_o(byp_o),
        .barrier_pulse_o(bar_o), .flush_pulse_o(fl_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reset_dut(input logic r, input logic i, input logic s, input logic f,
                             input logic [8:0] c);
        @(negedge clk);
        rst = 1; f_res = r; f_iso = i; f_ssb = s; f_fl = f; cap = c;
        req = 0; drained = 1; init_i = 0; enclave = 0; smm = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic op(input logic w, input logic [31:0] ix, input logic [63:0] d, input int hold,
                      output logic e, output logic [63:0] rd, output int nb, output int nf,
                      output int lat, output int early);
        @(negedge clk);
        req = 1; wr = w; idx = ix; wdata = d; drained = (hold == 0);
        nb = 0; nf = 0; lat = 0; early = 0; e = 0; rd = '0;
        forever begin
            @(negedge clk);
            lat++;
            if (bar_o) nb++;
            if (fl_o) nf++;
            if ((bar_o || fl_o) && !drained) early++;
            if (ack) begin
                e = err; rd = rdata; req = 0; drained = 1;
                break;
            end
            if (lat >= hold) drained = 1;
            if (lat > 60) begin
                req = 0; drained = 1;
                break;
            end
        end
    endtask

    task automatic acc(input logic w, input logic [31:0] ix, input logic [63:0] d,
                       output logic e, output logic [63:0] rd);
        int nb, nf, lat, early;
        op(w, ix, d, 0, e, rd, nb, nf, lat, early);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic        e;
        logic [63:0] rd;
        int          nb, nf, lat, early;

        reset_dut(1, 1, 1, 1, 9'h0A5);
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {59'b0, res_o, iso_o, byp_o, bar_o, fl_o}, 64'h0);
        chk("R1 ack", {63'b0, ack}, 64'h0);
        acc(0, 32'h48, 0, e, rd);
        chk("R1 ctrl read", rd, 64'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].idx, VECS[i].data, 0, e, rd, nb, nf, lat, early);
            chk($sformatf("R%0d vec%0d err", VECS[i].rq, i), {63'b0, e}, {63'b0, VECS[i].err});
            chk($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), rd, VECS[i].rd);
            chk($sformatf("R%0d vec%0d barrier", VECS[i].rq, i), 64'(nb), 64'(VECS[i].nb));
            chk($sformatf("R%0d vec%0d flush", VECS[i].rq, i), 64'(nf), 64'(VECS[i].nf));
            chk($sformatf("R%0d vec%0d latency", VECS[i].rq, i), 64'(lat),
                VECS[i].wr ? 64'd3 : 64'd1); // R9 latencies
        end
        chk("R2 outputs", {61'b0, res_o, iso_o, byp_o}, 64'h7);

        // R9 drain held low for 4 cycles
        op(1, 32'h49, 64'h1, 4, e, rd, nb, nf, lat, early);
        chk("R9 pulse count", 64'(nb), 64'd1);
        chk("R9 no pulse undrained", 64'(early), 64'd0);
        chk("R9 waited", 64'(lat > 4), 64'd1);

        // R10 fields captured at acceptance
        @(negedge clk);
        req = 1; wr = 1; idx = 32'h48; wdata = 64'h1; drained = 0;
        @(negedge clk);
        idx = 32'h49; wdata = 64'h7;
        repeat (3) @(negedge clk);
        chk("R10 no ack before drain", {63'b0, ack}, 64'h0);
        drained = 1;
        nb = 0;
        for (int k = 0; k < 10 && !ack; k++) begin
            @(negedge clk);
            if (bar_o) nb++;
        end
        chk("R10 err", {63'b0, err}, 64'h0);
        chk("R10 no barrier", 64'(nb), 64'd0);
        req = 0;
        acc(0, 32'h48, 0, e, rd);
        chk("R10 captured data", rd, 64'h1);

        // R11 init abandons pending write, keeps register
        @(negedge clk);
        req = 1; wr = 1; idx = 32'h49; wdata = 64'h1; drained = 0;
        repeat (2) @(negedge clk);
        init_i = 1;
        @(negedge clk);
        init_i = 0; req = 0; drained = 1;
        nb = 0; nf = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (bar_o) nb++;
            if (ack) nf++;
        end
        chk("R11 no pulse", 64'(nb), 64'd0);
        chk("R11 no ack", 64'(nf), 64'd0);
        acc(0, 32'h48, 0, e, rd);
        chk("R11 register kept", rd, 64'h1);

        // R12 enclave and system-management override
        @(negedge clk);
        enclave = 1;
        @(negedge clk);
        chk("R12 enclave forces", {63'b0, byp_o}, 64'h1);
        acc(0, 32'h48, 0, e, rd);
        chk("R12 stored bit kept", rd, 64'h1);
        @(negedge clk);
        enclave = 0; smm = 1;
        @(negedge clk);
        chk("R12 smm forces", {63'b0, byp_o}, 64'h1);
        smm = 0;
        @(negedge clk);
        chk("R12 released", {63'b0, byp_o}, 64'h0);

        // R3 restrict and flush absent
        reset_dut(0, 1, 1, 0, 9'h0A5);
        acc(1, 32'h48, 64'h1, e, rd);
        chk("R3 restrict bit faults", {63'b0, e}, 64'h1);
        acc(1, 32'h48, 64'h6, e, rd);
        chk("R3 legal bits ok", {63'b0, e}, 64'h0);
        acc(0, 32'h48, 0, e, rd);
        chk("R3 readback", rd, 64'h6);
        op(1, 32'h49, 64'h1, 0, e, rd, nb, nf, lat, early);
        chk("R5 no feature fault", {63'b0, e}, 64'h1);
        chk("R5 no feature no pulse", 64'(nb), 64'd0);
        op(1, 32'h10B, 64'h1, 0, e, rd, nb, nf, lat, early);
        chk("R6 no feature fault", {63'b0, e}, 64'h1);
        chk("R6 no feature no pulse", 64'(nf), 64'd0);

        // R4 isolation absent, bit dropped
        reset_dut(1, 0, 1, 1, 9'h0A5);
        acc(1, 32'h48, 64'h3, e, rd);
        chk("R4 no fault", {63'b0, e}, 64'h0);
        acc(0, 32'h48, 0, e, rd);
        chk("R4 bit dropped", rd, 64'h1);
        chk("R4 isolate out", {63'b0, iso_o}, 64'h0);

        // R3 store-bypass feature absent
        reset_dut(1, 1, 0, 1, 9'h0A5);
        acc(1, 32'h48, 64'h4, e, rd);
        chk("R3 bypass bit faults", {63'b0, e}, 64'h1);

        // R3 register absent, R7 other strap value
        reset_dut(0, 0, 0, 1, 9'h1FF);
        acc(0, 32'h48, 0, e, rd);
        chk("R3 absent read faults", {63'b0, e}, 64'h1);
        chk("R13 fault rdata", rd, 64'h0);
        acc(0, 32'h10A, 0, e, rd);
        chk("R7 capability all ones", rd, 64'h1FF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule